// File: doc/BRIEF.md
# Probe Fan-out and Acknowledgement Tracker

This block prepares one coherence probe transaction at a time. When a probe is launched it works out which agents must receive the probe, presents that set as a bit-vector, and loads a counter with the number of responses that will come back. Every response strobe then counts down. When the last response has been seen, the block emits a one-cycle completion pulse that the surrounding controller uses to move the transaction on.

The target set always starts as every core cluster. When the system is not running in processor-only mode, one accelerator-side node is added. It is either a directory node or a cache node, picked by a flag. Its index within its group comes from the address field just above the block offset. The agent that made the request is then taken out of the set. A target set that ends up empty still completes, one cycle after the zero count becomes visible. A synchronous clear input abandons the current transaction.

The tracker is a three-state machine. IDLE accepts a launch and moves to COLLECT when responses are owed, or to FIRE when none are. COLLECT counts responses down and moves to FIRE on the last one. FIRE emits the completion pulse and returns to IDLE. A clear sends any state back to IDLE.

Top module: `probe_fanout_tracker`

## Requirements
- R1: After reset, dest_o and pending_o are zero and done_o and err_o are low.
- R2: Target bits 0 to NUM_CLUSTERS-1 are the core clusters and are all set on a launch. The bit whose index equals req_id_i is then cleared. An index beyond the vector clears nothing, and the requester is removed even when it is the added node.
- R3: With cpu_only_i low, one extra bit is set at index NUM_CLUSTERS + s, or at NUM_CLUSTERS + NUM_ACCEL + s when to_cache_i is high. Here s = addr_i[OFFSET_BITS +: log2(NUM_ACCEL)]. With cpu_only_i high, no extra bit is set.
- R4: kind_i encodes the probe: 0 = invalidate with data, 1 = downgrade with data, 2 = invalidate without data, 3 = treated as 2. For kind 0 only, no_conflict_i high suppresses the extra node. For every other kind, no_conflict_i has no effect.
- R5: In the cycle after an accepted launch, pending_o equals the number of set bits in dest_o, and dest_o holds the launched set.
- R6: done_o is high during the cycle that follows the first cycle in which pending_o reads zero for a transaction. This includes a launch whose target set is empty.
- R7: In COLLECT, each cycle with ack_i high lowers pending_o by one in the next cycle.
- R8: done_o is never high for two consecutive cycles and fires once per transaction.
- R9: ack_i while nothing is owed raises err_o for one cycle, and pending_o stays zero. This covers IDLE, FIRE, and the launch cycle itself.
- R10: A launch while in COLLECT or FIRE is ignored: dest_o and pending_o are unchanged.
- R11: clr_i returns the block to IDLE with dest_o and pending_o zero, and no done_o or err_o follows. clr_i takes priority over launch_i and ack_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous per-transaction clear |
| launch_i | input | 1 | Start a probe transaction |
| kind_i | input | 2 | Probe kind code |
| req_id_i | input | ID_W | Requester index into the target vector |
| addr_i | input | ADDR_W | Block address of the probe |
| cpu_only_i | input | 1 | Processor-only mode, no accelerator node |
| to_cache_i | input | 1 | Extra node is a cache node rather than a directory node |
| no_conflict_i | input | 1 | Write request flagged as free of conflicts |
| ack_i | input | 1 | One probe response received |
| dest_o | output | DEST_W | Target bit-vector |
| pending_o | output | CNT_W | Responses still owed |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Unexpected response pulse |

## Verification
The bench drives two instances with the same stimulus. One has six clusters. The other has a single cluster, so it can produce an empty target set, which a design that waits for a response that never comes would hang on. Patterns include:
- a requester that is itself the selected accelerator node, to catch a design that removes the requester before adding the extra node;
- an out-of-range requester;
- a conflict-free flag on non-invalidate kinds, to catch a design that suppresses the node for the wrong probe kind.

Responses are also sent in the launch cycle, in FIRE, and after completion, to catch a counter that wraps to its maximum and a missing error pulse. A clear is raised together with a launch and a response, to catch a design that gives the clear the wrong priority.

// File: rtl/probe_fanout_pkg.sv
package probe_fanout_pkg;

    typedef enum logic [1:0] {
        PK_INV_DATA  = 2'd0,
        PK_DOWNGRADE = 2'd1,
        PK_INV_BARE  = 2'd2,
        PK_RESERVED  = 2'd3
    } probe_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_FIRE    = 2'd2
    } trk_state_e;

endpackage

// File: rtl/probe_target_builder.sv
module probe_target_builder
    import probe_fanout_pkg::*;
#(
    parameter int NUM_CLUSTERS = 6,
    parameter int NUM_ACCEL    = 4,
    parameter int ADDR_W       = 16,
    parameter int OFFSET_BITS  = 6,
    parameter int DEST_W       = NUM_CLUSTERS + 2 * NUM_ACCEL,
    parameter int ID_W         = 4,
    parameter int CNT_W        = 4
) (
    input  logic [1:0]        kind_i,
    input  logic [ID_W-1:0]   req_id_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cpu_only_i,
    input  logic              to_cache_i,
    input  logic              no_conflict_i,
    output logic [DEST_W-1:0] set_o,
    output logic [CNT_W-1:0]  count_o
);
    localparam int SEL_W = (NUM_ACCEL > 1) ? $clog2(NUM_ACCEL) : 1;

    logic [SEL_W-1:0] sel;
    logic             extra_on;
    int               tgt;

    generate
        if (NUM_ACCEL > 1) begin : g_sel_field
            assign sel = addr_i[OFFSET_BITS +: SEL_W];
        end else begin : g_sel_fixed
            assign sel = '0;
        end
    endgenerate

    wire unused_addr = ^addr_i;

    // Conflict-free write/atomic invalidates need no accelerator-side node.
    assign extra_on = !cpu_only_i &&
                      !((probe_kind_e'(kind_i) == PK_INV_DATA) && no_conflict_i);
    assign tgt = (to_cache_i ? (NUM_CLUSTERS + NUM_ACCEL) : NUM_CLUSTERS) + int'(sel);

    always_comb begin
        set_o = '0;
        for (int b = 0; b < DEST_W; b++) begin
            if (b < NUM_CLUSTERS)              set_o[b] = 1'b1;
            if (extra_on && (b == tgt))        set_o[b] = 1'b1;
            if (int'(req_id_i) == b)           set_o[b] = 1'b0;
        end
    end

    always_comb begin
        count_o = '0;
        for (int b = 0; b < DEST_W; b++) begin
            count_o = count_o + CNT_W'(set_o[b]);
        end
    end

endmodule

// File: rtl/probe_ack_counter.sv
module probe_ack_counter
    import probe_fanout_pkg::*;
#(
    parameter int DEST_W = 14,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              launch_i,
    input  logic              ack_i,
    input  logic [DEST_W-1:0] load_set_i,
    input  logic [CNT_W-1:0]  load_cnt_i,
    output logic [DEST_W-1:0] dest_o,
    output logic [CNT_W-1:0]  pending_o,
    output logic              done_o,
    output logic              err_o
);
    trk_state_e st_q, st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:    if (launch_i) st_d = (load_cnt_i == '0) ? ST_FIRE : ST_COLLECT;
                ST_COLLECT: if (ack_i && (pending_o == CNT_W'(1))) st_d = ST_FIRE;
                ST_FIRE:    st_d = ST_IDLE;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dest_o    <= '0;
            pending_o <= '0;
            done_o    <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            done_o <= 1'b0;
            err_o  <= 1'b0;
            if (clr_i) begin
                dest_o    <= '0;
                pending_o <= '0;
            end else begin
                unique case (st_q)
                    ST_IDLE: begin
                        if (launch_i) begin
                            dest_o    <= load_set_i;
                            pending_o <= load_cnt_i;
                        end
                        if (ack_i) err_o <= 1'b1;
                    end
                    ST_COLLECT: begin
                        if (ack_i) pending_o <= pending_o - CNT_W'(1);
                    end
                    ST_FIRE: begin
                        done_o <= 1'b1;
                        if (ack_i) err_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: loaded count matches the registered target set
    p_count_matches_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && launch_i && !clr_i) |=> (pending_o == CNT_W'($countones(dest_o))));

    // R6: FIRE always produces completion
    p_fire_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FIRE && !clr_i) |=> done_o);

    // R7: each response in COLLECT lowers the count by one
    p_ack_decrements_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_COLLECT && ack_i && !clr_i) |=> (pending_o == $past(pending_o) - CNT_W'(1)));

    // R8: completion is a single-cycle pulse
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: stray response flags and never wraps
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !launch_i && !clr_i && pending_o == '0) |=> (pending_o == '0 && err_o));

    // R10: launch outside IDLE leaves the target set alone
    p_busy_ignores_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !clr_i) |=> $stable(dest_o));

    // R11: clear empties the transaction
    p_clear_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pending_o == '0 && dest_o == '0 && !done_o && !err_o));

endmodule

// File: rtl/probe_fanout_tracker.sv
module probe_fanout_tracker #(
    parameter int NUM_CLUSTERS = 6,
    parameter int NUM_ACCEL    = 4,
    parameter int ADDR_W       = 16,
    parameter int OFFSET_BITS  = 6,
    localparam int DEST_W      = NUM_CLUSTERS + 2 * NUM_ACCEL,
    localparam int ID_W        = (DEST_W > 1) ? $clog2(DEST_W) : 1,
    localparam int CNT_W       = $clog2(DEST_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              launch_i,
    input  logic [1:0]        kind_i,
    input  logic [ID_W-1:0]   req_id_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cpu_only_i,
    input  logic              to_cache_i,
    input  logic              no_conflict_i,
    input  logic              ack_i,
    output logic [DEST_W-1:0] dest_o,
    output logic [CNT_W-1:0]  pending_o,
    output logic              done_o,
    output logic              err_o
);
    logic [DEST_W-1:0] set_w;
    logic [CNT_W-1:0]  cnt_w;

    probe_target_builder #(
        .NUM_CLUSTERS (NUM_CLUSTERS),
        .NUM_ACCEL    (NUM_ACCEL),
        .ADDR_W       (ADDR_W),
        .OFFSET_BITS  (OFFSET_BITS),
        .DEST_W       (DEST_W),
        .ID_W         (ID_W),
        .CNT_W        (CNT_W)
    ) u_builder (
        .kind_i        (kind_i),
        .req_id_i      (req_id_i),
        .addr_i        (addr_i),
        .cpu_only_i    (cpu_only_i),
        .to_cache_i    (to_cache_i),
        .no_conflict_i (no_conflict_i),
        .set_o         (set_w),
        .count_o       (cnt_w)
    );

    probe_ack_counter #(
        .DEST_W (DEST_W),
        .CNT_W  (CNT_W)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .launch_i   (launch_i),
        .ack_i      (ack_i),
        .load_set_i (set_w),
        .load_cnt_i (cnt_w),
        .dest_o     (dest_o),
        .pending_o  (pending_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );

endmodule

// File: tb/probe_ref.sv
module probe_ref #(
    parameter int NC  = 6,
    parameter int NA  = 4,
    parameter int OFF = 6,
    parameter int AW  = 16,
    parameter int DW  = NC + 2 * NA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          launch,
    input  logic          ack,
    input  logic [1:0]    kind,
    input  logic [3:0]    req,
    input  logic [AW-1:0] addr,
    input  logic          cpu,
    input  logic          cache,
    input  logic          ncf,
    output logic [DW-1:0] e_dest,
    output int            e_pend,
    output logic          e_done,
    output logic          e_err
);
    int phase = 0; // 0 waiting for launch, 1 counting, 2 about to complete
    initial begin
        e_dest = '0; e_pend = 0; e_done = 0; e_err = 0;
    end

    function automatic logic [DW-1:0] targets();
        logic [DW-1:0] t = '0;
        int idx;
        for (int i = 0; i < NC; i++) t[i] = 1'b1;
        if (!cpu && !(kind == 2'd0 && ncf)) begin
            idx = (int'(addr) >> OFF) % NA;
            t[(cache ? NC + NA : NC) + idx] = 1'b1;
        end
        if (int'(req) < DW) t[req] = 1'b0;
        return t;
    endfunction

    always @(posedge clk) begin
        e_done = 0;
        e_err  = 0;
        if (!rst_n) begin
            phase = 0; e_dest = '0; e_pend = 0;
        end else if (clr) begin
            phase = 0; e_dest = '0; e_pend = 0;
        end else if (phase == 0) begin
            if (ack) e_err = 1;
            if (launch) begin
                e_dest = targets();
                e_pend = $countones(e_dest);
                phase  = (e_pend == 0) ? 2 : 1;
            end
        end else if (phase == 1) begin
            if (ack) begin
                e_pend = e_pend - 1;
                if (e_pend == 0) phase = 2;
            end
        end else begin
            e_done = 1;
            if (ack) e_err = 1;
            phase = 0;
        end
    end
endmodule

// File: tb/test_probe_fanout_tracker.sv
`timescale 1ns/1ps
module test_probe_fanout_tracker;
    localparam int NA = 4, AW = 16, OFF = 6;
    localparam int NC_A = 6, DW_A = NC_A + 2 * NA;
    localparam int NC_B = 1, DW_B = NC_B + 2 * NA;

    logic clk = 0;
    always #4 clk = ~clk; // 125 MHz

    logic rst_n = 0, clr = 0, launch = 0, ack = 0;
    logic [1:0] kind = 0;
    logic [3:0] req = 0;
    logic [AW-1:0] addr = 0;
    logic cpu = 0, cache = 0, ncf = 0;

    logic [DW_A-1:0] dest_a; logic [3:0] pend_a; logic done_a, err_a;
    logic [DW_B-1:0] dest_b; logic [3:0] pend_b; logic done_b, err_b;
    logic [DW_A-1:0] x_dest_a; int x_pend_a; logic x_done_a, x_err_a;
    logic [DW_B-1:0] x_dest_b; int x_pend_b; logic x_done_b, x_err_b;

    int n_tests = 0, n_fail = 0, cycles = 0;
    bit armed = 0;

    probe_fanout_tracker #(.NUM_CLUSTERS(NC_A), .NUM_ACCEL(NA), .ADDR_W(AW), .OFFSET_BITS(OFF))
    i_probe_fanout_tracker (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .launch_i(launch), .kind_i(kind),
        .req_id_i(req), .addr_i(addr), .cpu_only_i(cpu), .to_cache_i(cache),
        .no_conflict_i(ncf), .ack_i(ack), .dest_o(dest_a), .pending_o(pend_a),
        .done_o(done_a), .err_o(err_a));

    probe_fanout_tracker #(.NUM_CLUSTERS(NC_B), .NUM_ACCEL(NA), .ADDR_W(AW), .OFFSET_BITS(OFF))
    i_probe_fanout_tracker_solo (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .launch_i(launch), .kind_i(kind),
        .req_id_i(req), .addr_i(addr), .cpu_only_i(cpu), .to_cache_i(cache),
        .no_conflict_i(ncf), .ack_i(ack), .dest_o(dest_b), .pending_o(pend_b),
        .done_o(done_b), .err_o(err_b));

    probe_ref #(.NC(NC_A), .NA(NA), .OFF(OFF), .AW(AW)) u_ref_a (
        .clk(clk), .rst_n(rst_n), .clr(clr), .launch(launch), .ack(ack), .kind(kind),
        .req(req), .addr(addr), .cpu(cpu), .cache(cache), .ncf(ncf),
        .e_dest(x_dest_a), .e_pend(x_pend_a), .e_done(x_done_a), .e_err(x_err_a));

    probe_ref #(.NC(NC_B), .NA(NA), .OFF(OFF), .AW(AW)) u_ref_b (
        .clk(clk), .rst_n(rst_n), .clr(clr), .launch(launch), .ack(ack), .kind(kind),
        .req(req), .addr(addr), .cpu(cpu), .cache(cache), .ncf(ncf),
        .e_dest(x_dest_b), .e_pend(x_pend_b), .e_done(x_done_b), .e_err(x_err_b));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison with the reference models
    always @(negedge clk) if (armed) begin
        chk("R2/R3/R4", "dest A", int'(dest_a), int'(x_dest_a));
        chk("R5/R7", "pending A", int'(pend_a), x_pend_a);
        chk("R6/R8", "done A", int'(done_a), int'(x_done_a));
        chk("R9", "err A", int'(err_a), int'(x_err_a));
        chk("R2/R3/R4", "dest B", int'(dest_b), int'(x_dest_b));
        chk("R5/R7", "pending B", int'(pend_b), x_pend_b);
        chk("R6/R8", "done B", int'(done_b), int'(x_done_b));
        chk("R9", "err B", int'(err_b), int'(x_err_b));
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic launch_txn(input logic [1:0] k, input logic [3:0] r, input int sel,
                              input logic c, input logic ch, input logic nf);
        @(negedge clk);
        kind = k; req = r; addr = AW'(sel << OFF); cpu = c; cache = ch; ncf = nf;
        launch = 1;
        @(negedge clk);
        launch = 0;
    endtask

    task automatic send_acks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ack = 1;
            @(negedge clk); ack = 0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic clear_all();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
        chk("R11", "dest A after clear", int'(dest_a), 0);
        chk("R11", "pending A after clear", int'(pend_a), 0);
    endtask

    initial begin
        logic [DW_A-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1;
        armed = 1;
        chk("R1", "dest A reset", int'(dest_a), 0);
        chk("R1", "pending A reset", int'(pend_a), 0);
        chk("R1", "done/err A reset", int'({done_a, err_a}), 0);
        chk("R1", "pending B reset", int'(pend_b), 0);

        // invalidate with data, directory node 1; B: requester is the extra node
        launch_txn(2'd0, 4'd2, 1, 0, 0, 0);
        chk("R3", "dest A inv dir sel1", int'(dest_a), 14'b00000010111011);
        chk("R2", "dest B requester is extra node", int'(dest_b), 1);
        send_acks(3, 1);
        held = dest_a;
        launch_txn(2'd1, 4'd4, 3, 0, 1, 0);
        chk("R10", "dest A launch while busy", int'(dest_a), int'(held));
        chk("R10", "pending A launch while busy", int'(pend_a), 3);
        send_acks(3, 0);
        repeat (3) @(negedge clk);
        clear_all();

        // downgrade to cache node 3, conflict-free flag must not matter
        launch_txn(2'd1, 4'd0, 3, 0, 1, 1);
        chk("R4", "dest A downgrade keeps node", int'(dest_a), 14'b10000000111110);
        send_acks(7, 0);
        repeat (3) @(negedge clk);
        clear_all();

        // conflict-free invalidate: no accelerator node
        launch_txn(2'd0, 4'd5, 2, 0, 0, 1);
        chk("R4", "pending A conflict-free", int'(pend_a), 5);
        send_acks(5, 2);
        clear_all();

        // processor-only bare invalidate
        launch_txn(2'd2, 4'd9, 1, 1, 0, 0);
        chk("R3", "dest A cpu only", int'(dest_a), 14'b00000000111111);
        send_acks(6, 0);
        clear_all();

        // reserved kind, out-of-range requester
        launch_txn(2'd3, 4'd15, 2, 0, 1, 1);
        chk("R4", "dest A reserved kind", int'(dest_a), 14'b01000000111111);
        send_acks(9, 0);
        clear_all();

        // empty set on B
        launch_txn(2'd0, 4'd0, 0, 1, 0, 0);
        chk("R6", "pending B empty set", int'(pend_b), 0);
        chk("R6", "done B not yet", int'(done_b), 0);
        @(negedge clk);
        chk("R6", "done B empty set", int'(done_b), 1);
        @(negedge clk);
        chk("R8", "done B single pulse", int'(done_b), 0);
        send_acks(5, 0);
        repeat (2) @(negedge clk);
        clear_all();

        // response in the launch cycle
        @(negedge clk);
        kind = 0; req = 1; addr = 0; cpu = 0; cache = 0; ncf = 0; launch = 1; ack = 1;
        @(negedge clk); launch = 0; ack = 0;
        chk("R9", "err A ack in launch cycle", int'(err_a), 1);
        chk("R5", "pending A after launch", int'(pend_a), 6);
        send_acks(6, 0);
        repeat (3) @(negedge clk);
        clear_all();

        // clear wins over launch and ack
        launch_txn(2'd0, 4'd1, 0, 0, 0, 0);
        send_acks(2, 0);
        @(negedge clk); clr = 1; launch = 1; ack = 1;
        @(negedge clk); clr = 0; launch = 0; ack = 0;
        chk("R11", "dest A clear priority", int'(dest_a), 0);
        chk("R11", "err A clear priority", int'(err_a), 0);
        send_acks(1, 0);
        chk("R9", "pending A stray ack", int'(pend_a), 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule